// File: doc/BRIEF.md
# Three-Lane Word Serializer with Forwarded Frame Clock

This block takes a 21-bit parallel word once per frame and sends it out on three single-bit serial lanes. Each lane carries seven bits per frame. A fourth lane carries a forwarded clock that marks the frame boundary.

The block runs entirely from the bit-rate clock. That clock is seven times the parallel word rate. An internal slot counter stands for the phase-aligned parallel clock. The word is taken on the bit-clock edge that ends slot 6. That edge is where the parallel clock would rise. The block raises `take_o` for the whole bit cycle that comes before that edge. The source must hold `word_i` steady through that cycle. There is no back-pressure: a word is taken every frame whether or not it is new.

The block has an active-low powerdown input, `pwrdn_n`. A startup hold-off models the time the link takes to lock. The output-enable flag goes high only after `pwrdn_n` has stayed high for a set number of bit cycles, and then only at a frame boundary. While the flag is low, every lane is driven to 0. This stands in for a tri-stated output.

Top module: `tri_lane_serializer`

## Requirements
- R1: While `rst_n` is low, `oe_o`, `fclk_o`, `lane_o` and `take_o` are all 0. The slot count, the lock count and the stored words are all cleared.
- R2: `take_o` is high for exactly one bit cycle in every seven, and the first time is the seventh cycle after reset. The word taken is the value of `word_i` at the rising edge that ends a `take_o`-high cycle. Values of `word_i` at any other edge have no effect on the lanes.
- R3: Lane k (where `lane_o[k]`, k = 0..2) carries word bits 7k to 7k+6. Bits go out lowest index first: in slot s of a frame (s = 0..6), lane k shows bit 7k+s.
- R4: A word taken at edge E starts going out (its bit-0 slot) in the cycle that follows edge E+7. That is one full frame of latency.
- R5: While enabled, `fclk_o` is 1 in slots 0 to 3 and 0 in slots 4 to 6. Its rising edge therefore falls on the bit-0 slot.
- R6: After any rising edge at which `pwrdn_n` is sampled low, `oe_o`, `fclk_o` and all lanes are 0.
- R7: `oe_o` rises only at the edge that ends a `take_o`-high cycle. It does so only when `pwrdn_n` has been sampled high at the LOCK_CYCLES consecutive edges before that edge, counted from reset or from the last edge at which `pwrdn_n` was sampled low.
- R8: Sampling `pwrdn_n` low for even one edge, or applying reset, restarts the lock count from zero.
- R9: Whenever `oe_o` is 0, `fclk_o` and every bit of `lane_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit-rate clock, seven cycles per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low powerdown; also starts the lock count when high |
| word_i | input | 21 | Parallel word, sampled at the end of the `take_o` cycle |
| take_o | output | 1 | High during the last slot of each frame; marks the capture edge |
| lane_o | output | 3 | Serial data lanes, one bit per bit-clock cycle |
| fclk_o | output | 1 | Forwarded frame clock lane, 4 slots high and 3 low |
| oe_o | output | 1 | Output enable; low while powered down or not yet locked |

## Verification
The lanes are driven with four kinds of input:
- Free-running pseudo-random words that change every bit cycle. Only the value present at the capture edge may show up, so these separate correct capture timing from sampling at the wrong slot.
- A single 1 walked through all 21 bit positions, one position per frame. This catches any swap of lane or slot order.
- A single marker word presented only during the take cycle, with zeros around it. This fixes the frame latency exactly.
- Powerdown pulses of a single cycle and of many cycles, placed mid-frame and mid-lock, plus a reset in the middle of the run. These show whether the lock count restarts and whether enable returns only on a frame boundary.

// File: rtl/tls_pkg.sv
package tls_pkg;
  localparam int unsigned TLS_LANES_DEF   = 3;
  localparam int unsigned TLS_RATIO_DEF   = 7;
  localparam int unsigned TLS_HIGH_DEF    = 4;
  localparam int unsigned TLS_LOCK_DEF    = 5950000;
endpackage

// File: rtl/tls_frame_timer.sv
module tls_frame_timer #(
  parameter int unsigned RATIO = 7,
  parameter int unsigned HIGH  = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_o,
  output logic high_o
);
  localparam int unsigned SW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [SW-1:0] LAST_SLOT = SW'(RATIO - 1);
  localparam logic [SW-1:0] HIGH_END  = SW'(HIGH);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  slot_q <= '0;
    else if (slot_q == LAST_SLOT) slot_q <= '0;
    else                         slot_q <= slot_q + 1'b1;
  end

  assign last_o = (slot_q == LAST_SLOT);
  assign high_o = (slot_q < HIGH_END);
endmodule

// File: rtl/tls_lock_gate.sv
module tls_lock_gate #(
  parameter int unsigned LOCK_CYCLES = 5950000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic frame_last,
  output logic oe_o
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_END = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          oe_q;
  logic          locked;

  assign locked = (cnt_q == LOCK_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!pwrdn_n) cnt_q <= '0;
    else if (!locked)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    oe_q <= 1'b0;
    else if (!pwrdn_n)             oe_q <= 1'b0;
    else if (locked && frame_last) oe_q <= 1'b1;
  end

  assign oe_o = oe_q;
endmodule

// File: rtl/tls_lane_shift.sv
module tls_lane_shift #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (load) sh_q <= din;
    else           sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer
  import tls_pkg::*;
#(
  parameter int unsigned LANES       = TLS_LANES_DEF,
  parameter int unsigned RATIO       = TLS_RATIO_DEF,
  parameter int unsigned HIGH        = TLS_HIGH_DEF,
  parameter int unsigned LOCK_CYCLES = TLS_LOCK_DEF,
  localparam int unsigned WORD_W     = LANES * RATIO
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              pwrdn_n,
  input  logic [WORD_W-1:0] word_i,
  output logic              take_o,
  output logic [LANES-1:0]  lane_o,
  output logic              fclk_o,
  output logic              oe_o
);
  logic              frame_last;
  logic              phase_high;
  logic              oe;
  logic [WORD_W-1:0] hold_q;
  logic [LANES-1:0]  lane_raw;

  tls_frame_timer #(.RATIO(RATIO), .HIGH(HIGH)) u_timer (
    .clk    (clk_bit),
    .rst_n  (rst_n),
    .last_o (frame_last),
    .high_o (phase_high)
  );

  tls_lock_gate #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk        (clk_bit),
    .rst_n      (rst_n),
    .pwrdn_n    (pwrdn_n),
    .frame_last (frame_last),
    .oe_o       (oe)
  );

  // Capture stage: the word waits here one frame before its lanes load it.
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (frame_last) hold_q <= word_i;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tls_lane_shift #(.W(RATIO)) u_shift (
      .clk   (clk_bit),
      .rst_n (rst_n),
      .load  (frame_last),
      .din   (hold_q[k*RATIO +: RATIO]),
      .bit_o (lane_raw[k])
    );
  end

  assign take_o = frame_last;
  assign oe_o   = oe;
  assign lane_o = lane_raw & {LANES{oe}};
  assign fclk_o = phase_high & oe;
endmodule

// File: rtl/tri_lane_serializer_chk.sv
module tri_lane_serializer_chk #(
  parameter int unsigned LANES = 3,
  parameter int unsigned RATIO = 7
) (
  input logic             clk_bit,
  input logic             rst_n,
  input logic             pwrdn_n,
  input logic             take_o,
  input logic [LANES-1:0] lane_o,
  input logic             fclk_o,
  input logic             oe_o
);
  localparam int unsigned GW = $clog2(RATIO + 1);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (take_o) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  AST_TAKE_SPACING: assert property (@(posedge clk_bit) disable iff (!rst_n)
    take_o == (gap_q == GW'(RATIO - 1))); // R2

  AST_IDLE_LANES: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !oe_o |-> (lane_o == '0 && !fclk_o)); // R9

  AST_PDN_DISABLES: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pwrdn_n |=> !oe_o); // R6

  AST_OE_ON_FRAME: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(oe_o) |-> $past(take_o)); // R7

  AST_FCLK_RISE_FRAME: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (oe_o && $past(oe_o) && $rose(fclk_o)) |-> $past(take_o)); // R5
endmodule

bind tri_lane_serializer tri_lane_serializer_chk #(.LANES(LANES), .RATIO(RATIO)) u_chk (
  .clk_bit (clk_bit),
  .rst_n   (rst_n),
  .pwrdn_n (pwrdn_n),
  .take_o  (take_o),
  .lane_o  (lane_o),
  .fclk_o  (fclk_o),
  .oe_o    (oe_o)
);

// File: tb/tri_lane_serializer_bench.sv
`timescale 1ns/1ps
module tri_lane_serializer_bench;
  localparam int LOCK = 40;

  logic        clk_bit = 1'b0;
  logic        rst_n   = 1'b0;
  logic        pwrdn_n = 1'b0;
  logic [20:0] word_i  = '0;
  logic        take_o, fclk_o, oe_o;
  logic [2:0]  lane_o;

  int n_cmp  = 0;
  int n_fail = 0;

  // behavioural reference state
  int          m_slot = 0;
  int          m_cnt  = 0;
  bit          m_oe   = 0;
  logic [20:0] m_held = '0;
  logic [20:0] m_tx   = '0;
  logic [31:0] seed   = 32'h1234_5678;

  always #2 clk_bit = ~clk_bit;

  tri_lane_serializer #(.LOCK_CYCLES(LOCK)) u_tri_lane_serializer (
    .clk_bit (clk_bit),
    .rst_n   (rst_n),
    .pwrdn_n (pwrdn_n),
    .word_i  (word_i),
    .take_o  (take_o),
    .lane_o  (lane_o),
    .fclk_o  (fclk_o),
    .oe_o    (oe_o)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit last_p, lock_p;
    if (!rst_n) begin
      m_slot = 0; m_cnt = 0; m_oe = 0; m_held = '0; m_tx = '0;
    end else begin
      last_p = (m_slot == 6);
      lock_p = (m_cnt == LOCK);
      if (last_p) begin m_tx = m_held; m_held = word_i; end
      if (!pwrdn_n) m_oe = 0;
      else if (lock_p && last_p) m_oe = 1;
      if (!pwrdn_n) m_cnt = 0;
      else if (m_cnt < LOCK) m_cnt++;
      m_slot = last_p ? 0 : m_slot + 1;
    end
  endtask

  task automatic step(input string tag);
    logic [2:0] exp_lane;
    @(posedge clk_bit);
    model_edge();
    @(negedge clk_bit);
    for (int k = 0; k < 3; k++) exp_lane[k] = m_oe ? m_tx[7*k + m_slot] : 1'b0;
    check(tag, "lane_o", int'(lane_o), int'(exp_lane));
    check(tag, "oe_o", int'(oe_o), int'(m_oe));
    check(rst_n ? "R5" : "R1", "fclk_o", int'(fclk_o), int'(m_oe && m_slot < 4));
    check(rst_n ? "R2" : "R1", "take_o", int'(take_o), int'(m_slot == 6));
  endtask

  function automatic logic [20:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[28:8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk_bit);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    int bitpos;
    // R1 reset state
    for (int i = 0; i < 4; i++) step("R1");
    rst_n = 1'b1; pwrdn_n = 1'b1;
    // R7 / R9 lock hold-off with outputs idle, random words
    for (int i = 0; i < 56; i++) begin word_i = next_rand(); step("R7"); end
    // R3 random words changing every cycle (R2 only capture edge matters)
    for (int i = 0; i < 70; i++) begin word_i = next_rand(); step("R3"); end
    // R3 walking one, one bit position per frame
    bitpos = 0;
    word_i = 21'd1;
    for (int i = 0; i < 21*7; i++) begin
      step("R3");
      if (take_o) begin bitpos = (bitpos + 1) % 21; word_i = 21'd1 << bitpos; end
    end
    // R4 marker present only during the take cycle
    word_i = '0;
    for (int i = 0; i < 42; i++) begin
      step("R4");
      word_i = (take_o && i < 10) ? 21'h15A5C3 : 21'h0;
    end
    // R6 powerdown mid-frame
    word_i = 21'h1FFFFF;
    step("R6");
    pwrdn_n = 1'b0;
    for (int i = 0; i < 12; i++) step("R6");
    pwrdn_n = 1'b1;
    // R8 relock after release, with a one-cycle glitch mid-count
    for (int i = 0; i < 20; i++) begin word_i = next_rand(); step("R8"); end
    pwrdn_n = 1'b0;
    step("R8");
    pwrdn_n = 1'b1;
    for (int i = 0; i < 60; i++) begin word_i = next_rand(); step("R8"); end
    // R8 reset mid-run restarts lock
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 62; i++) begin word_i = next_rand(); step("R8"); end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule